// File: doc/BRIEF.md
# Byte-Write Nonvolatile Memory Controller

This block is the control core of a 2K x 8 parallel memory whose bytes can be rewritten one at a time. A host drives three active-low strobes, an address and a data byte without any clock. The core samples them in its own clock domain, removes short noise pulses on the strobes, and serves reads from an internal byte array. It also runs self-timed byte writes into that array. It does not own a bidirectional pin. It presents the read byte together with a drive-enable, and its ready line is a pull-down request meant for a shared open-drain net.

A write begins when chip select and write strobe are both low with output enable high. The address is taken when the later of the two strobes falls. The data is taken when the earlier of the two rises. A fixed count of clock cycles then passes before the byte lands in the array. During that time the ready line is pulled low. A read of the byte being written returns the inverse of its top bit, so a host can poll for completion. After reset, and whenever the supply-good flag drops, writes stay locked out for a set number of cycles.

Top module: `eep_byte_ctrl`

## Requirements
- R1: While reset is held and just after it, `bus_drive` and `ready_line_pull` are 0, and every byte of the array reads back 0xFF until it is written.
- R2: `bus_drive` is 1 exactly when the filtered strobes show chip select low, output enable low and write strobe high. Any other strobe combination gives 0, including chip select, output enable and write strobe all low.
- R3: A write is accepted whether the write strobe or chip select is the strobe that falls last and rises first. An accepted write produces one pulse on `ready_line_pull`.
- R4: The stored address is the one present when the second strobe fell, not one applied later. The stored byte is the one present when the first strobe rose, not one applied earlier.
- R5: `ready_line_pull` stays high for exactly WRITE_CYC consecutive cycles per accepted write. The new byte is in the array from the cycle in which the line is released.
- R6: While a write is in progress, a read of its address returns the inverse of the written bit 7 on bit 7, with bits 6..0 reading 0. A read of any other address returns its stored byte.
- R7: After a write completes, a read of its address returns the full written byte.
- R8: A strobe excursion shorter than GLITCH_CYC clock cycles after synchronization is not seen, and a write strobe pulse that short starts no write.
- R9: No write is accepted before PWRUP_CYC cycles have passed with `supply_ok` high after reset. A low `supply_ok` blocks writes and restarts that count.
- R10: Write attempts made while a write is in progress are ignored. Strobes held low across the end of a write do not start another one, because a new write needs a fresh write condition.
- R11: If output enable goes low after the address is taken but before a strobe rises, the write is abandoned and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above write threshold |
| chip_sel_n | input | 1 | Active-low chip select strobe (asynchronous) |
| out_en_n | input | 1 | Active-low output enable strobe (asynchronous) |
| wr_en_n | input | 1 | Active-low write strobe (asynchronous) |
| addr | input | ADDR_W | Byte address |
| bus_in | input | DATA_W | Byte from the host bus |
| bus_out | output | DATA_W | Byte offered to the host bus |
| bus_drive | output | 1 | Tri-state enable for `bus_out` |
| ready_line_pull | output | 1 | 1 pulls the shared ready line low (write in progress) |

## Verification
The hardest case to reach is the clean separation of the two latch moments. The address must be captured on one strobe and the data on the other, with the bus changing in between. The write routine therefore drives a wrong byte before the first strobe falls and moves the address away after the second falls. It puts the true byte on the bus only just before the rising strobe. It runs once with each strobe in control. A second hard case is stimulus that overlaps an ongoing write, such as strobes held low over its end or a full second write sequence inside the busy window. The bench uses a long write time so that a complete second sequence fits inside it.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } eep_state_e;

    // bit positions of the strobe vector
    localparam int STB_N  = 3;
    localparam int STB_CE = 0;
    localparam int STB_OE = 1;
    localparam int STB_WE = 2;
endpackage

// File: rtl/eep_strobe_filter.sv
module eep_strobe_filter #(
    parameter int GLITCH_CYC = 4,
    parameter bit RST_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d    = f_q;
        f_d.s1 = raw_i;
        f_d.s2 = f_q.s1;
        if (f_q.s2 == f_q.filt) begin
            f_d.cnt = '0;
        end else if (f_q.cnt == CW'(GLITCH_CYC - 1)) begin
            f_d.filt = f_q.s2;
            f_d.cnt  = '0;
        end else begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{s1: RST_LVL, s2: RST_LVL, filt: RST_LVL, cnt: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign sync_o = f_q.s2;
    assign filt_o = f_q.filt;
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eep_byte_ctrl.sv
module eep_byte_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int WRITE_CYC  = 40,
    parameter int GLITCH_CYC = 4,
    parameter int PWRUP_CYC  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_drive,
    output logic              ready_line_pull
);
    localparam int TMR_W = $clog2(WRITE_CYC + 1);
    localparam int PU_W  = $clog2(PWRUP_CYC + 1);

    typedef struct packed {
        eep_state_e        st;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;
        logic [TMR_W-1:0]  tmr;
        logic [PU_W-1:0]   pcnt;
        logic              cond;
        logic [DATA_W-1:0] dout;
        logic              doe;
    } regs_t;

    regs_t r_d, r_q;

    logic [STB_N-1:0]  stb_raw, stb_s, stb_f;
    logic              ce_hi, oe_hi, we_hi;
    logic              wr_cond, lock_done, commit_en;
    logic [DATA_W-1:0] rd_data;

    assign stb_raw[STB_CE] = chip_sel_n;
    assign stb_raw[STB_OE] = out_en_n;
    assign stb_raw[STB_WE] = wr_en_n;

    for (genvar i = 0; i < STB_N; i++) begin : g_flt
        eep_strobe_filter #(
            .GLITCH_CYC(GLITCH_CYC),
            .RST_LVL   (1'b1)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (stb_raw[i]),
            .sync_o(stb_s[i]),
            .filt_o(stb_f[i])
        );
    end

    assign ce_hi = stb_f[STB_CE];
    assign oe_hi = stb_f[STB_OE];
    assign we_hi = stb_f[STB_WE];

    eep_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_cells (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit_en),
        .wr_addr(r_q.waddr),
        .wr_data(r_q.wdata),
        .rd_addr(addr),
        .rd_data(rd_data)
    );

    always_comb begin
        r_d       = r_q;
        commit_en = 1'b0;
        lock_done = (r_q.pcnt == PU_W'(PWRUP_CYC));
        wr_cond   = !ce_hi && !we_hi && oe_hi;
        r_d.cond  = wr_cond;

        // power-on / supply lockout counter
        if (!supply_ok) begin
            r_d.pcnt = '0;
        end else if (!lock_done) begin
            r_d.pcnt = r_q.pcnt + 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_cond && !r_q.cond && lock_done && supply_ok) begin
                    r_d.st    = ST_ARMED;
                    r_d.waddr = addr;
                end
            end
            ST_ARMED: begin
                if (!supply_ok || !oe_hi) begin
                    r_d.st = ST_IDLE;
                end else if (ce_hi || we_hi) begin
                    r_d.wdata = bus_in;
                    r_d.tmr   = TMR_W'(WRITE_CYC - 1);
                    r_d.st    = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (r_q.tmr == '0) begin
                    commit_en = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        r_d.doe = !ce_hi && !oe_hi && we_hi;
        if (r_q.st == ST_BUSY && addr == r_q.waddr) begin
            r_d.dout = {~r_q.wdata[DATA_W-1], {(DATA_W-1){1'b0}}};
        end else begin
            r_d.dout = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_out         = r_q.dout;
    assign bus_drive       = r_q.doe;
    assign ready_line_pull = (r_q.st == ST_BUSY);
endmodule

// File: rtl/eep_byte_ctrl_chk.sv
module eep_byte_ctrl_chk
    import eep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             supply_ok,
    input logic             bus_drive,
    input logic             ready_line_pull,
    input logic             commit_en,
    input logic             lock_done,
    input logic [STB_N-1:0] stb_f,
    input logic [STB_N-1:0] stb_s
);
    logic [STB_N-1:0] read_pat;
    always_comb begin
        read_pat         = '0;
        read_pat[STB_WE] = 1'b1;
    end

    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> ($past(stb_f) == read_pat));

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_line_pull) |-> $past(commit_en));

    // R5
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> ready_line_pull);

    // R9
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_line_pull) |-> ($past(lock_done) && $past(supply_ok)));

    // R8
    glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_f ^ $past(stb_f)) & (stb_f ^ $past(stb_s))) == '0);
endmodule

bind eep_byte_ctrl eep_byte_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .bus_drive      (bus_drive),
    .ready_line_pull(ready_line_pull),
    .commit_en      (commit_en),
    .lock_done      (lock_done),
    .stb_f          (stb_f),
    .stb_s          (stb_s)
);

// File: tb/tb_eep_byte_ctrl.sv
module tb_eep_byte_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WC = 100;
    localparam int GL = 4;
    localparam int PU = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b1;
    logic        chip_sel_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  bus_in = '0;
    logic [7:0]  bus_out;
    logic        bus_drive;
    logic        ready_line_pull;

    eep_byte_ctrl #(
        .ADDR_W(11), .DATA_W(8), .WRITE_CYC(WC), .GLITCH_CYC(GL), .PWRUP_CYC(PU)
    ) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
        .addr(addr), .bus_in(bus_in), .bus_out(bus_out),
        .bus_drive(bus_drive), .ready_line_pull(ready_line_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nvec = 0;
    int nerr = 0;
    int busy_pulses = 0;
    int busy_len_last = 0;
    int run_len = 0;

    typedef struct {
        logic [10:0] a;
        logic [7:0]  exp;
        logic [7:0]  msk;
        string       req;
    } item_t;
    item_t sbq[$];
    event  smp_ev;

    // busy pulse monitor
    always @(negedge clk) begin
        if (ready_line_pull) begin
            run_len = run_len + 1;
        end else if (run_len > 0) begin
            busy_len_last = run_len;
            busy_pulses   = busy_pulses + 1;
            run_len       = 0;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(smp_ev);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                nvec++;
                if (!bus_drive || ((bus_out & it.msk) !== (it.exp & it.msk))) begin
                    nerr++;
                    $display("FAIL %s addr=%h actual=%h/drive%0d expected=%h/drive1",
                             it.req, it.a, bus_out & it.msk, bus_drive, it.exp & it.msk);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [10:0] a, input logic [7:0] e,
                           input logic [7:0] m, input string req);
        item_t it;
        step(1);
        addr = a; wr_en_n = 1'b1; chip_sel_n = 1'b0; out_en_n = 1'b0;
        step(12);
        it.a = a; it.exp = e; it.msk = m; it.req = req;
        sbq.push_back(it);
        ->smp_ev;
        step(1);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        step(10);
    endtask

    // ce_ctrl=0: write strobe falls last and rises first; ce_ctrl=1: chip select does
    task automatic do_write(input logic [10:0] a, input logic [7:0] d, input bit ce_ctrl);
        step(1);
        addr = a; bus_in = ~d; out_en_n = 1'b1;
        if (ce_ctrl) wr_en_n = 1'b0; else chip_sel_n = 1'b0;
        step(10);
        if (ce_ctrl) chip_sel_n = 1'b0; else wr_en_n = 1'b0;
        step(10);
        addr = a ^ 11'h7FF;
        bus_in = d;
        step(4);
        if (ce_ctrl) chip_sel_n = 1'b1; else wr_en_n = 1'b1;
        step(10);
        if (ce_ctrl) wr_en_n = 1'b1; else chip_sel_n = 1'b1;
        step(2);
        bus_in = 8'h00;
    endtask

    task automatic wait_idle();
        while (ready_line_pull) step(1);
        step(4);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int p0;
        step(5);
        // R1: reset state
        chk("R1 drive in reset", int'(bus_drive), 0);
        chk("R1 ready in reset", int'(ready_line_pull), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 ready after reset", int'(ready_line_pull), 0);

        // R9: write during power-up lockout is dropped
        do_write(11'd5, 8'h3C, 1'b0);
        step(4);
        chk("R9 lockout write", busy_pulses, 0);
        step(PU);
        do_read(11'd5, 8'hFF, 8'hFF, "R1/R9 erased byte");

        // R3/R5/R6/R7: write-strobe controlled
        p0 = busy_pulses;
        do_write(11'd10, 8'hA5, 1'b0);
        do_read(11'd10, 8'h00, 8'h80, "R6 polling bit7");
        do_read(11'd5, 8'hFF, 8'hFF, "R6 other address");
        wait_idle();
        chk("R3 we-controlled pulse", busy_pulses, p0 + 1);
        chk("R5 busy length", busy_len_last, WC);
        do_read(11'd10, 8'hA5, 8'hFF, "R7 data after write");
        do_read(11'd10 ^ 11'h7FF, 8'hFF, 8'hFF, "R4 late address ignored");

        // R3/R4: chip-select controlled
        p0 = busy_pulses;
        do_write(11'h123, 8'h5A, 1'b1);
        do_read(11'h123, 8'h80, 8'h80, "R6 polling bit7 ce");
        wait_idle();
        chk("R3 ce-controlled pulse", busy_pulses, p0 + 1);
        chk("R5 busy length ce", busy_len_last, WC);
        do_read(11'h123, 8'h5A, 8'hFF, "R4 data at first rise");

        // R10: second write inside busy window
        p0 = busy_pulses;
        do_write(11'h200, 8'h11, 1'b0);
        do_write(11'h201, 8'h22, 1'b0);
        wait_idle();
        chk("R10 overlap write", busy_pulses, p0 + 1);
        do_read(11'h201, 8'hFF, 8'hFF, "R10 ignored byte");
        do_read(11'h200, 8'h11, 8'hFF, "R7 first byte");

        // R10: strobes held low across end of write
        p0 = busy_pulses;
        do_write(11'h300, 8'h33, 1'b1);
        addr = 11'h301; bus_in = 8'h44;
        wr_en_n = 1'b0; chip_sel_n = 1'b0; out_en_n = 1'b1;
        wait_idle();
        step(20);
        chk("R10 held strobes", busy_pulses, p0 + 1);
        wr_en_n = 1'b1;
        step(10);
        chip_sel_n = 1'b1;
        step(10);
        chk("R10 held strobes release", busy_pulses, p0 + 1);
        do_read(11'h301, 8'hFF, 8'hFF, "R10 held byte");

        // R8: short write strobe pulses
        p0 = busy_pulses;
        addr = 11'h040; bus_in = 8'h77;
        chip_sel_n = 1'b0;
        step(10);
        wr_en_n = 1'b0; step(2); wr_en_n = 1'b1;
        step(10);
        wr_en_n = 1'b0; step(3); wr_en_n = 1'b1;
        step(20);
        chk("R8 glitch rejected", busy_pulses, p0);
        chip_sel_n = 1'b1;
        step(10);
        do_read(11'h040, 8'hFF, 8'hFF, "R8 byte unchanged");

        // R11: output enable low before strobe rises
        p0 = busy_pulses;
        addr = 11'h050; bus_in = 8'h99;
        chip_sel_n = 1'b0; step(10);
        wr_en_n = 1'b0; step(10);
        out_en_n = 1'b0; step(10);
        wr_en_n = 1'b1; step(10);
        chip_sel_n = 1'b1; out_en_n = 1'b1; step(10);
        chk("R11 abort no busy", busy_pulses, p0);
        do_read(11'h050, 8'hFF, 8'hFF, "R11 byte unchanged");

        // R2: drive enable decode
        p0 = busy_pulses;
        chip_sel_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b0;
        step(12);
        chk("R2 all low no drive", int'(bus_drive), 0);
        wr_en_n = 1'b1; step(12);
        chk("R2 read drives", int'(bus_drive), 1);
        chip_sel_n = 1'b1; step(12);
        chk("R2 ce high no drive", int'(bus_drive), 0);
        chip_sel_n = 1'b0; out_en_n = 1'b1; step(12);
        chk("R2 oe high no drive", int'(bus_drive), 0);
        chip_sel_n = 1'b1; step(10);
        chk("R2 no write from oe-low", busy_pulses, p0);

        // R9: supply low blocks writes and restarts lockout
        p0 = busy_pulses;
        supply_ok = 1'b0;
        do_write(11'h060, 8'h66, 1'b0);
        step(4);
        chk("R9 supply low", busy_pulses, p0);
        supply_ok = 1'b1;
        do_write(11'h061, 8'h67, 1'b0);
        step(4);
        chk("R9 lockout restart", busy_pulses, p0);
        step(PU + 10);
        do_write(11'h062, 8'h6E, 1'b1);
        wait_idle();
        chk("R9 write after lockout", busy_pulses, p0 + 1);
        do_read(11'h060, 8'hFF, 8'hFF, "R9 byte 60");
        do_read(11'h061, 8'hFF, 8'hFF, "R9 byte 61");
        do_read(11'h062, 8'h6E, 8'hFF, "R9 byte 62");

        step(5);
        summary();
        $finish;
    end
endmodule